// File: doc/BRIEF.md
# Signal Notification Register Pair

This block holds two 32-bit inbound notification words that a host, or a group of remote senders, use to wake an accelerator core. The host reaches the words and a small mode register through a memory-mapped port, where it can write and read without side effects. The accelerator reaches the words through a read-only channel. A channel read hands back the current word and empties it. If the word is still zero, the read waits.

Each word has its own mode. In overwrite mode a host write replaces the word, which suits a single sender passing a value. In accumulate mode a host write is ORed into the word, so several senders can each raise their own bits and the accelerator collects all of them in one read. A per-word pending indication (a count of 0 or 1) lets the accelerator poll before it commits to a blocking read.

Top module: `sig_notify_pair`

## Requirements
- R1: After reset both notification words read 0, the mode register reads 0 (both words in overwrite mode), `ch_count` is 0 and `ch_rd_ack` is low.
- R2: A host write to address 0 or 1 with the word in overwrite mode (mode bit 0) replaces that word with `host_wr_data` at the next clock edge.
- R3: A host write to address 0 or 1 with the word in accumulate mode (mode bit 1) sets the word to the bitwise OR of its old value and `host_wr_data`.
- R4: `host_rd_data` shows the value at `host_addr` in the same cycle, and host reads never change any word.
- R5: While `ch_rd_req` is high and the word picked by `ch_sel` (0 or 1) is non-zero, `ch_rd_ack` is high in that cycle, `ch_rd_data` carries the word, and the word is zero after the clock edge.
- R6: While `ch_rd_req` is high and the selected word is zero, `ch_rd_ack` stays low. The read completes in the first cycle in which the word is non-zero.
- R7: When a channel read and a host write to the same word fall in one cycle, the read returns the old value and the word then holds exactly the written data, whatever the mode.
- R8: Bit i of `ch_count` is 1 exactly when word i is non-zero.
- R9: Address 2 is the mode register. Bit i of a write sets the mode of word i. A read returns the two mode bits in bits 1:0, with all higher bits zero.
- R10: The mode of one word does not affect how writes to the other word are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 2 | Host address: 0, 1 words, 2 mode register |
| host_wr_data | input | 32 | Host write data |
| host_rd_data | output | 32 | Host read data for `host_addr` (non-destructive) |
| ch_rd_req | input | 1 | Accelerator channel read request, held until acknowledged |
| ch_sel | input | 1 | Which word the channel reads |
| ch_rd_ack | output | 1 | Channel read completes this cycle |
| ch_rd_data | output | 32 | Word returned by the channel read |
| ch_count | output | 2 | Per-word pending indication |

## Verification
The hardest case to reach is a channel read that completes in the same cycle as a host write to the same word. The old value must come back, and the word must be left holding only the new bits, even in accumulate mode where the write would normally OR in. The bench builds a non-zero word first, then raises the read request and the write in one cycle to that word, once in each mode. A second difficult case is a read that stalls on an empty word and is released by a write that lands while the request is still pending. The bench holds the request across several idle cycles and then writes.

// File: rtl/sn_pkg.sv
package sn_pkg;
   typedef enum logic {
      SN_OVERWRITE  = 1'b0,
      SN_ACCUMULATE = 1'b1
   } sn_mode_e;

   function automatic logic [31:0] sn_merge(input logic [31:0] base,
                                            input logic [31:0] din,
                                            input sn_mode_e   mode);
      return (mode == SN_ACCUMULATE) ? (base | din) : din;
   endfunction
endpackage

// File: rtl/sn_cfg_reg.sv
module sn_cfg_reg #(
   parameter int NUM_SIG = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_hit,
   input  logic [NUM_SIG-1:0] wr_bits,
   output logic [NUM_SIG-1:0] mode_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      mode_q <= '0;
      else if (wr_hit) mode_q <= wr_bits;
   end
endmodule

// File: rtl/sn_slot.sv
module sn_slot
   import sn_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              accum,
   input  logic              take,
   output logic [DATA_W-1:0] val_q
);
   logic [DATA_W-1:0] base;
   logic [DATA_W-1:0] nxt;

   always_comb begin
      base = take ? '0 : val_q;
      if (!wr_hit)     nxt = base;
      else if (accum)  nxt = base | wr_data;
      else             nxt = wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= nxt;
   end
endmodule

// File: rtl/sn_chan.sv
module sn_chan #(
   parameter int NUM_SIG = 2,
   parameter int DATA_W  = 32,
   parameter int SEL_W   = 1
) (
   input  logic [NUM_SIG-1:0][DATA_W-1:0] vals,
   input  logic                           req,
   input  logic [SEL_W-1:0]               sel,
   output logic                           ack,
   output logic [DATA_W-1:0]              data,
   output logic [NUM_SIG-1:0]             take,
   output logic [NUM_SIG-1:0]             count
);
   logic [NUM_SIG-1:0] pend;

   for (genvar i = 0; i < NUM_SIG; i++) begin : g_pend
      assign pend[i] = |vals[i];
   end

   always_comb begin
      data = '0;
      take = '0;
      for (int i = 0; i < NUM_SIG; i++) begin
         if (int'(sel) == i) begin
            data    = vals[i];
            take[i] = req & pend[i];
         end
      end
   end

   assign ack   = |take;
   assign count = pend;
endmodule

// File: rtl/sig_notify_pair.sv
module sig_notify_pair #(
   parameter int NUM_SIG = 2,
   parameter int DATA_W  = 32,
   localparam int ADDR_W = $clog2(NUM_SIG + 1),
   localparam int SEL_W  = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_en,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wr_data,
   output logic [DATA_W-1:0] host_rd_data,
   input  logic              ch_rd_req,
   input  logic [SEL_W-1:0]  ch_sel,
   output logic              ch_rd_ack,
   output logic [DATA_W-1:0] ch_rd_data,
   output logic [NUM_SIG-1:0] ch_count
);
   localparam int CFG_ADDR = NUM_SIG;

   if (NUM_SIG < 1 || NUM_SIG > DATA_W) begin : g_bad_num
      $error("sig_notify_pair: NUM_SIG must lie in 1..DATA_W");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("sig_notify_pair: DATA_W must be positive");
   end

   logic [NUM_SIG-1:0][DATA_W-1:0] sig_q;
   logic [NUM_SIG-1:0]             mode_q;
   logic [NUM_SIG-1:0]             take;
   logic                           cfg_hit;

   assign cfg_hit = host_wr_en && (int'(host_addr) == CFG_ADDR);

   sn_cfg_reg #(.NUM_SIG(NUM_SIG)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (cfg_hit),
      .wr_bits (host_wr_data[NUM_SIG-1:0]),
      .mode_q  (mode_q)
   );

   for (genvar i = 0; i < NUM_SIG; i++) begin : g_slot
      logic hit;
      assign hit = host_wr_en && (int'(host_addr) == i);
      sn_slot #(.DATA_W(DATA_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_hit  (hit),
         .wr_data (host_wr_data),
         .accum   (mode_q[i]),
         .take    (take[i]),
         .val_q   (sig_q[i])
      );
   end

   sn_chan #(.NUM_SIG(NUM_SIG), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_chan (
      .vals  (sig_q),
      .req   (ch_rd_req),
      .sel   (ch_sel),
      .ack   (ch_rd_ack),
      .data  (ch_rd_data),
      .take  (take),
      .count (ch_count)
   );

   always_comb begin
      host_rd_data = '0;
      for (int i = 0; i < NUM_SIG; i++) begin
         if (int'(host_addr) == i) host_rd_data = sig_q[i];
      end
      if (int'(host_addr) == CFG_ADDR) host_rd_data[NUM_SIG-1:0] = mode_q;
   end
endmodule

// File: rtl/sn_notify_chk.sv
module sn_notify_chk #(
   parameter int NUM_SIG = 2,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 2,
   parameter int SEL_W   = 1
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           host_wr_en,
   input logic [ADDR_W-1:0]              host_addr,
   input logic [DATA_W-1:0]              host_wr_data,
   input logic                           ch_rd_req,
   input logic [SEL_W-1:0]               ch_sel,
   input logic                           ch_rd_ack,
   input logic [DATA_W-1:0]              ch_rd_data,
   input logic [NUM_SIG-1:0][DATA_W-1:0] sig_q,
   input logic [NUM_SIG-1:0]             mode_q
);
   logic same_word;
   assign same_word = host_wr_en && (int'(host_addr) == int'(ch_sel));

   p_ack_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_rd_ack |-> (ch_rd_data != '0));

   p_clear_on_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_rd_ack && !same_word) |=> (sig_q[$past(ch_sel)] == '0));

   p_stall_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_rd_req && (sig_q[ch_sel] == '0)) |-> !ch_rd_ack);

   p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_rd_ack && same_word) |=> (sig_q[$past(ch_sel)] == $past(host_wr_data)));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr_en && !ch_rd_ack) |=> $stable(sig_q));

   p_or_accum_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_en && (host_addr == '0) && mode_q[0] && !(ch_rd_ack && (ch_sel == '0)))
      |=> (sig_q[0] == ($past(sig_q[0]) | $past(host_wr_data))));
endmodule

bind sig_notify_pair sn_notify_chk #(
   .NUM_SIG(NUM_SIG), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_wr_en   (host_wr_en),
   .host_addr    (host_addr),
   .host_wr_data (host_wr_data),
   .ch_rd_req    (ch_rd_req),
   .ch_sel       (ch_sel),
   .ch_rd_ack    (ch_rd_ack),
   .ch_rd_data   (ch_rd_data),
   .sig_q        (sig_q),
   .mode_q       (mode_q)
);

// File: tb/sig_notify_pair_tb_top.sv
module sig_notify_pair_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [1:0]  host_addr = '0;
   logic [31:0] host_wr_data = '0;
   logic [31:0] host_rd_data;
   logic        ch_rd_req = 1'b0;
   logic [0:0]  ch_sel = '0;
   logic        ch_rd_ack;
   logic [31:0] ch_rd_data;
   logic [1:0]  ch_count;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] m_sig [2];
   logic [1:0]  m_mode;
   logic [31:0] exp_q [$];

   always #(CLK_P/2) clk = ~clk;

   sig_notify_pair dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
      .host_wr_data(host_wr_data), .host_rd_data(host_rd_data),
      .ch_rd_req(ch_rd_req), .ch_sel(ch_sel), .ch_rd_ack(ch_rd_ack),
      .ch_rd_data(ch_rd_data), .ch_count(ch_count)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [1:0] a);
      if (a < 2) return m_sig[a];
      return {30'b0, m_mode};
   endfunction

   // One bus cycle: drive at negedge, predict, then update the model.
   task automatic cyc(input bit we, input logic [1:0] a, input logic [31:0] d,
                      input bit rq, input bit sel, input string tag);
      @(negedge clk);
      host_wr_en = we; host_addr = a; host_wr_data = d;
      ch_rd_req = rq; ch_sel = sel;
      #1;
      check(host_rd_data == m_read(a), "R4 host read", host_rd_data, m_read(a));
      check(ch_count == {|m_sig[1], |m_sig[0]}, "R8 count", {30'b0, ch_count},
            {30'b0, |m_sig[1], |m_sig[0]});
      if (rq) begin
         if (m_sig[sel] != 0) exp_q.push_back(m_sig[sel]);
         else check(ch_rd_ack == 1'b0, {"R6 stall ", tag}, {31'b0, ch_rd_ack}, 32'd0);
      end
      #2;
      if (rq && m_sig[sel] != 0) m_sig[sel] = 0;
      if (we) begin
         if (a == 2) m_mode = d[1:0];
         else if (a < 2) m_sig[a] = m_mode[a] ? (m_sig[a] | d) : d;
      end
   endtask

   task automatic idle(input logic [1:0] a);
      cyc(1'b0, a, 32'h0, 1'b0, 1'b0, "idle");
   endtask

   // Monitor: pops expected channel results as acks appear.
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && ch_rd_ack) begin
            if (exp_q.size() == 0) check(1'b0, "R5 unexpected ack", ch_rd_data, 32'h0);
            else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               check(ch_rd_data == e, "R5/R7 channel data", ch_rd_data, e);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      check(1'b0, "watchdog", 32'h0, 32'h0);
      finish_run();
   end

   initial begin
      m_sig[0] = 0; m_sig[1] = 0; m_mode = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check(ch_count == 2'b00, "R1 count", {30'b0, ch_count}, 32'h0);
      check(ch_rd_ack == 1'b0, "R1 ack", {31'b0, ch_rd_ack}, 32'h0);
      idle(2'd0); idle(2'd1); idle(2'd2);

      // R2 overwrite
      cyc(1'b1, 2'd0, 32'h0000_00A5, 1'b0, 1'b0, "w");
      cyc(1'b1, 2'd0, 32'h0000_0030, 1'b0, 1'b0, "w");
      idle(2'd0);
      check(host_rd_data == 32'h30, "R2 overwrite", host_rd_data, 32'h30);
      // R4 repeated host reads leave the word
      idle(2'd0); idle(2'd0); idle(2'd0);
      // R5 channel take, then empty
      cyc(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, "take0");
      idle(2'd0);
      check(host_rd_data == 32'h0 && ch_count[0] == 1'b0, "R5 cleared", host_rd_data, 32'h0);

      // R6 stall on empty word 1, released by a write while pending
      cyc(1'b0, 2'd1, 32'h0, 1'b1, 1'b1, "s1");
      cyc(1'b0, 2'd1, 32'h0, 1'b1, 1'b1, "s2");
      cyc(1'b0, 2'd1, 32'h0, 1'b1, 1'b1, "s3");
      cyc(1'b1, 2'd1, 32'h0000_0007, 1'b1, 1'b1, "s4");
      cyc(1'b0, 2'd1, 32'h0, 1'b1, 1'b1, "release");
      idle(2'd1);

      // R9 mode register: word 0 accumulate, word 1 overwrite
      cyc(1'b1, 2'd2, 32'hFFFF_FFFD, 1'b0, 1'b0, "cfg");
      idle(2'd2);
      check(host_rd_data == 32'h1, "R9 mode readback", host_rd_data, 32'h1);

      // R3 accumulate on word 0, R10 overwrite still on word 1
      cyc(1'b1, 2'd0, 32'h0000_0001, 1'b0, 1'b0, "or");
      cyc(1'b1, 2'd0, 32'h0000_0004, 1'b0, 1'b0, "or");
      cyc(1'b1, 2'd0, 32'h0000_0100, 1'b0, 1'b0, "or");
      cyc(1'b1, 2'd1, 32'h0000_00F0, 1'b0, 1'b0, "ow");
      cyc(1'b1, 2'd1, 32'h0000_000F, 1'b0, 1'b0, "ow");
      idle(2'd0);
      check(host_rd_data == 32'h105, "R3 accumulate", host_rd_data, 32'h105);
      idle(2'd1);
      check(host_rd_data == 32'h0F, "R10 independent mode", host_rd_data, 32'h0F);

      // R7 collision in accumulate mode and in overwrite mode
      cyc(1'b1, 2'd0, 32'h0000_0008, 1'b1, 1'b0, "col0");
      idle(2'd0);
      check(host_rd_data == 32'h8, "R7 collide accumulate", host_rd_data, 32'h8);
      cyc(1'b1, 2'd1, 32'h0000_0022, 1'b1, 1'b1, "col1");
      idle(2'd1);
      check(host_rd_data == 32'h22, "R7 collide overwrite", host_rd_data, 32'h22);

      // R9/R10 swap modes, word 1 now accumulates
      cyc(1'b1, 2'd2, 32'h0000_0002, 1'b0, 1'b0, "cfg2");
      cyc(1'b1, 2'd1, 32'h0000_4000, 1'b0, 1'b0, "or1");
      cyc(1'b1, 2'd0, 32'h0000_0010, 1'b0, 1'b0, "ow0");
      idle(2'd1);
      check(host_rd_data == 32'h4022, "R10 word1 accumulate", host_rd_data, 32'h4022);
      idle(2'd0);
      check(host_rd_data == 32'h10, "R2 word0 overwrite", host_rd_data, 32'h10);

      // Drain both
      cyc(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, "d0");
      cyc(1'b0, 2'd1, 32'h0, 1'b1, 1'b1, "d1");
      idle(2'd0);
      check(ch_count == 2'b00, "R8 all empty", {30'b0, ch_count}, 32'h0);
      idle(2'd1);
      check(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 32'h0);
      finish_run();
   end
endmodule